// File: doc/BRIEF.md
# Up-Counting Event Timer with Compare Flag

This block is a register-mapped timer. A programmable prescaler divides the input clock, and each prescaler tick advances an up-counter that wraps to zero once it reaches a reload limit. One compare register raises a flag when the counter steps onto its value. Software can force an update event that restarts the count and loads the buffered settings. Two status flags, one for updates and one for compare matches, drive a single interrupt line through per-flag enables.

Software programs the block over a simple register bus. It sets a divide ratio and then issues a forced update so that ratio becomes active. It then starts the counter, or schedules compare deadlines as the current count plus a delta. The counter width is a parameter (16 or 32). Registers hold only that many bits, so a reduced-width instance can be recognised by writing all ones and reading the value back.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset, the counter, compare, prescaler, control, enable and status registers read 0. The reload register reads all ones for the counter width. The irq output and bus_rdata are 0.
- R2: A read returns on bus_rdata one clock after the address is presented, with 0 in unused bits and at unmapped offsets. Offsets: 0x00 control, 0x0C interrupt enable, 0x10 status, 0x14 event trigger (reads 0), 0x24 counter, 0x28 prescaler, 0x2C reload limit, 0x34 compare. Counter, reload and compare keep CNT_W bits and the prescaler keeps 16 bits, so writing 0xFFFFFFFF to the reload register reads back 0xFFFF when CNT_W=16.
- R3: While control bit 0 (run) is 1, the counter advances once every (active prescaler + 1) clocks. While run is 0, it holds.
- R4: A prescaler write changes only a buffer. The active divide ratio takes the buffer value only at an update event.
- R5: A tick that finds the counter equal to the reload limit sets the counter to 0. If control bit 1 (update suppress) is 0, this is an update event and it sets status bit 0.
- R6: While update suppress is 1, such a wrap still returns the counter to 0. It does not set status bit 0 and does not load the prescaler or reload shadows.
- R7: With control bit 7 (reload buffering) at 0, the limit is the reload register itself. With bit 7 at 1, the limit is a shadow copy that is loaded at each update event.
- R8: Writing a value with bit 0 set to offset 0x14 is an update event. It zeroes the counter and the prescaler phase, loads both shadows and sets status bit 0, whatever the setting of update suppress.
- R9: Status bit 1 is set when a tick moves the counter onto the compare value, including the move from the limit to 0. This happens whether or not the compare interrupt is enabled.
- R10: A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A flag set by hardware in the same clock stays set.
- R11: irq is a registered output equal to (status0 AND enable bit 0) OR (status1 AND enable bit 1), as the flags stood one clock earlier.
- R12: With control bit 3 (one-pulse) at 1, an update event clears run, and the counter stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a compare match across the wrap. The counter has to pass from the reload limit to zero and land on a compare value that is smaller than the count at the moment of scheduling. The stimulus sets the full-range limit, writes the counter to just below the top, and places the compare a few counts past zero. A second hard case is a buffered prescaler change that must stay invisible until an update event. The bench writes a new ratio while the counter runs and holds the counter address on the bus, so every tick spacing is compared against the reference model before and after the wrap.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int PSC_W  = 16;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_IEN  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_TRIG = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_CNT  = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_PSC  = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_LIM  = 8'h2C;
  localparam logic [BUS_AW-1:0] OFS_CMP  = 8'h34;

  localparam int CB_RUN  = 0;
  localparam int CB_USUP = 1;
  localparam int CB_ONEP = 3;
  localparam int CB_LBUF = 7;

  typedef struct packed {
    logic lbuf;
    logic onep;
    logic usup;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          load,
  input  logic [PW-1:0] div_buf,
  output logic          tick
);
  logic [PW-1:0] phase;
  logic [PW-1:0] div_act;

  assign tick = run && (phase == div_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      div_act <= '0;
    end else begin
      if (restart)   phase <= '0;
      else if (tick) phase <= '0;
      else if (run)  phase <= phase + 1'b1;
      if (load) div_act <= div_buf;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase <= div_act)); // R3
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          trig,
  input  logic          usup,
  input  logic          lbuf,
  input  logic [CW-1:0] lim_reg,
  input  logic [CW-1:0] cmp_reg,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wd,
  output logic [CW-1:0] count,
  output logic          upd,
  output logic          cmatch
);
  logic [CW-1:0] lim_sh;
  logic [CW-1:0] lim;
  logic [CW-1:0] nxt;
  logic          wrap;

  assign lim    = lbuf ? lim_sh : lim_reg;
  assign wrap   = tick && (count == lim);
  assign nxt    = wrap ? '0 : count + 1'b1;
  assign upd    = (wrap && !usup) || trig;
  assign cmatch = tick && (nxt == cmp_reg);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      lim_sh <= '1;
    end else begin
      if (cnt_we)    count <= cnt_wd;
      else if (trig) count <= '0;
      else if (tick) count <= nxt;
      if (upd) lim_sh <= lim_reg;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wrap && !cnt_we) |=> (count == '0)); // R5
  AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wrap && usup && !trig) |=> $stable(lim_sh)); // R6
  AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (trig && !cnt_we) |=> (count == '0)); // R8
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq
);
  localparam int PAD_C = BUS_DW - CNT_W;
  localparam int PAD_P = BUS_DW - PSC_W;

  ctrl_t             ctrl;
  logic [1:0]        ien;
  logic [1:0]        stat;
  logic [PSC_W-1:0]  psc_reg;
  logic [CNT_W-1:0]  lim_reg;
  logic [CNT_W-1:0]  cmp_reg;
  logic [CNT_W-1:0]  count;
  logic              tick, upd, cmatch, trig, cnt_we;
  logic [1:0]        stat_keep;
  logic [BUS_DW-1:0] rd_mux;

  assign trig   = bus_we && (bus_addr == OFS_TRIG) && bus_wdata[0];
  assign cnt_we = bus_we && (bus_addr == OFS_CNT);

  evt_prescaler #(.PW(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl.run), .restart(trig), .load(upd),
    .div_buf(psc_reg), .tick(tick)
  );

  evt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .trig(trig), .usup(ctrl.usup),
    .lbuf(ctrl.lbuf), .lim_reg(lim_reg), .cmp_reg(cmp_reg),
    .cnt_we(cnt_we), .cnt_wd(bus_wdata[CNT_W-1:0]),
    .count(count), .upd(upd), .cmatch(cmatch)
  );

  assign stat_keep = (bus_we && bus_addr == OFS_STAT) ? bus_wdata[1:0] : 2'b11;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL: begin
        rd_mux[CB_RUN]  = ctrl.run;
        rd_mux[CB_USUP] = ctrl.usup;
        rd_mux[CB_ONEP] = ctrl.onep;
        rd_mux[CB_LBUF] = ctrl.lbuf;
      end
      OFS_IEN:  rd_mux[1:0] = ien;
      OFS_STAT: rd_mux[1:0] = stat;
      OFS_CNT:  rd_mux = {{PAD_C{1'b0}}, count};
      OFS_PSC:  rd_mux = {{PAD_P{1'b0}}, psc_reg};
      OFS_LIM:  rd_mux = {{PAD_C{1'b0}}, lim_reg};
      OFS_CMP:  rd_mux = {{PAD_C{1'b0}}, cmp_reg};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      ien       <= '0;
      stat      <= '0;
      psc_reg   <= '0;
      lim_reg   <= '1;
      cmp_reg   <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq       <= |(stat & ien);
      stat      <= (stat & stat_keep) | {cmatch, upd};
      if (bus_we) begin
        case (bus_addr)
          OFS_CTRL: ctrl <= '{lbuf: bus_wdata[CB_LBUF], onep: bus_wdata[CB_ONEP],
                              usup: bus_wdata[CB_USUP], run: bus_wdata[CB_RUN]};
          OFS_IEN:  ien     <= bus_wdata[1:0];
          OFS_PSC:  psc_reg <= bus_wdata[PSC_W-1:0];
          OFS_LIM:  lim_reg <= bus_wdata[CNT_W-1:0];
          OFS_CMP:  cmp_reg <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (upd && ctrl.onep) ctrl.run <= 1'b0;
    end
  end

  AST_CMP_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmatch |=> stat[1]); // R9
  AST_ONEPULSE_STOP: assert property (@(posedge clk) disable iff (rst)
    (upd && ctrl.onep) |=> !ctrl.run); // R12
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int CW = 16;
  localparam logic [31:0] MASK = (CW == 32) ? 32'hFFFF_FFFF : ((32'd1 << CW) - 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h24;
  logic [31:0] wd = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  evt_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wd), .bus_we(we),
    .bus_rdata(rdata), .irq(irq)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  logic  armed = 1'b0;
  logic  done = 1'b0;

  // reference model state
  bit          m_run, m_usup, m_onep, m_lbuf;
  logic [1:0]  m_ien, m_stat;
  logic [31:0] m_psc, m_div, m_phase, m_cnt, m_lim, m_lsh, m_cmp, m_rd;
  bit          m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {24'd0, m_lbuf, 3'd0, m_onep, 1'b0, m_usup, m_run};
      8'h0C: return {30'd0, m_ien};
      8'h10: return {30'd0, m_stat};
      8'h24: return m_cnt;
      8'h28: return m_psc;
      8'h2C: return m_lim;
      8'h34: return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_run, m_usup, m_onep, m_lbuf} = '0;
      m_ien = 0; m_stat = 0; m_psc = 0; m_div = 0; m_phase = 0;
      m_cnt = 0; m_lim = MASK; m_lsh = MASK; m_cmp = 0; m_rd = 0; m_irq = 0;
    end else begin
      bit ug, tk, ov, up, cm, old_onep;
      logic [31:0] lim, nx;
      ug  = we && addr == 8'h14 && wd[0];
      tk  = m_run && m_phase == m_div;
      lim = m_lbuf ? m_lsh : m_lim;
      ov  = tk && m_cnt == lim;
      nx  = ov ? 0 : ((m_cnt + 1) & MASK);
      up  = (ov && !m_usup) || ug;
      cm  = tk && nx == m_cmp;
      old_onep = m_onep;
      m_rd  = m_read(addr);
      m_irq = |(m_stat & m_ien);
      m_stat = (m_stat & ((we && addr == 8'h10) ? wd[1:0] : 2'b11)) | {cm, up};
      if (up) begin m_div = m_psc; m_lsh = m_lim; end
      if (ug || tk) m_phase = 0; else if (m_run) m_phase = m_phase + 1;
      if (ug) m_cnt = 0; else if (tk) m_cnt = nx;
      if (we) case (addr)
        8'h00: begin m_run = wd[0]; m_usup = wd[1]; m_onep = wd[3]; m_lbuf = wd[7]; end
        8'h0C: m_ien = wd[1:0];
        8'h24: m_cnt = wd & MASK;
        8'h28: m_psc = wd & 32'hFFFF;
        8'h2C: m_lim = wd & MASK;
        8'h34: m_cmp = wd & MASK;
        default: ;
      endcase
      if (up && old_onep) m_run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !rst && !done) begin
      check({cur_req, " rdata"}, rdata, m_rd);
      check({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 8'h24;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a;
    @(negedge clk); check(req, rdata, exp); addr = 8'h24;
  endtask

  task automatic idle(input int n, input string req);
    cur_req = req;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h24, 32'd0, "R1 counter");
    rd(8'h2C, MASK, "R1 reload");
    rd(8'h10, 32'd0, "R1 status");
    armed = 1'b1;
    // R2 readback truncation
    cur_req = "R2";
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, 32'h0000_FFFF, "R2 reload width");
    wr(8'h34, 32'h0001_2345);
    rd(8'h34, 32'h0000_2345, "R2 compare width");
    wr(8'h28, 32'h0001_FFFF);
    rd(8'h28, 32'h0000_FFFF, "R2 prescaler width");
    rd(8'h14, 32'd0, "R2 trigger reads 0");
    rd(8'h40, 32'd0, "R2 unmapped");
    // R8 forced update with prescaler 2
    cur_req = "R8";
    wr(8'h28, 32'd2);
    wr(8'h2C, 32'd9);
    wr(8'h34, 32'd5);
    wr(8'h14, 32'd1);
    rd(8'h24, 32'd0, "R8 counter zeroed");
    rd(8'h10, 32'd1, "R8 update flag");
    wr(8'h10, 32'd0);
    // R3/R5/R9/R11 running with interrupts
    cur_req = "R11";
    wr(8'h0C, 32'd3);
    wr(8'h00, 32'd1);
    idle(70, "R3 R5 R9 R11");
    cur_req = "R10";
    wr(8'h10, 32'd2);
    idle(10, "R10");
    wr(8'h10, 32'd0);
    // R4 buffered prescaler
    cur_req = "R4";
    wr(8'h28, 32'd0);
    idle(60, "R4");
    // R6 suppressed update
    wr(8'h00, 32'd0);
    wr(8'h34, 32'd100);
    wr(8'h28, 32'd3);
    wr(8'h2C, 32'd3);
    wr(8'h14, 32'd1);
    wr(8'h10, 32'd0);
    wr(8'h00, 32'h3);
    idle(50, "R6");
    rd(8'h10, 32'd0, "R6 no update flag");
    // R7 reload buffering
    wr(8'h00, 32'h81);
    wr(8'h2C, 32'd6);
    idle(40, "R7");
    wr(8'h00, 32'h01);
    idle(30, "R7 direct");
    // R9 compare across the wrap
    wr(8'h00, 32'd0);
    wr(8'h28, 32'd0);
    wr(8'h2C, MASK);
    wr(8'h14, 32'd1);
    wr(8'h10, 32'd0);
    wr(8'h24, MASK - 32'd4);
    wr(8'h34, 32'd3);
    wr(8'h0C, 32'd2);
    wr(8'h00, 32'd1);
    idle(12, "R9 wrap");
    rd(8'h10, 32'd3, "R9 wrap flags");
    // R12 one-pulse
    wr(8'h00, 32'd0);
    wr(8'h2C, 32'd4);
    wr(8'h14, 32'd1);
    wr(8'h00, 32'h9);
    idle(20, "R12");
    rd(8'h00, 32'h8, "R12 run cleared");
    rd(8'h24, 32'd0, "R12 counter stopped");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule